// File: doc/BRIEF.md
# Four-Bank SDRAM Command Timing Monitor

This block sits passively on the command pins of a four-bank synchronous DRAM. It receives chip select, the three strobes, clock enable, A10, the bank address and a flag that says whether the device is programmed for full-page bursts. It does not drive the bus. Each bank is tracked as open or closed, along with three per-bank timers: cycles since the bank's last activate, a reactivation hold-off, and the remaining length of any auto-precharge burst. One global timer counts cycles since the last activate to any bank.

A command that breaks a bank-state rule or a minimum-spacing rule produces a one-cycle flag on the clock edge after the command. The flag carries a numeric reason code and the bank at fault. All timing limits are parameters counted in clock cycles. The burst length is a parameter. A bench or a larger verification environment uses the block to catch controller bugs as they happen.

Top module: `sdram_cmd_checker`

## Requirements
- R1: A command is taken from (CS#,RAS#,CAS#,WE#) at each rising edge where CKE was high on the previous edge. The encodings are: 1xxx deselect, 0111 no-op, 0011 activate, 0101 read, 0100 write, 0010 precharge, 0001 refresh (self-refresh entry when CKE is also low), 0110 burst stop. The reason codes are 0 none, 1 bank closed, 2 tRCD, 3 bank already open, 4 tRC, 5 tRRD, 6 reactivate too early, 7 tRAS, 8 auto-precharge interrupted, 9 auto-precharge in full-page mode, 10 illegal burst stop, 11 refresh with open bank, 12 missing no-op after CKE exit. The flag, code and bank are registered and appear one cycle after the command. The flag is high exactly when the code is non-zero, and reset clears all three. Deselect and no-op never raise the flag or change any bank.
- R2: A read or write to an open bank fewer than T_RCD cycles after its activate gives code 2.
- R3: A read or write to a closed bank gives code 1. A deselect that carries the activate strobe pattern does not open the bank.
- R4: An activate to a bank that is already open, or that is still inside an auto-precharge burst, gives code 3.
- R5: An activate to a bank fewer than T_RC cycles after that bank's previous activate gives code 4.
- R6: An activate fewer than T_RRD cycles after an activate to any bank gives code 5, and the activated bank is reported.
- R7: An activate fewer than T_RP cycles after an explicit precharge closed that bank gives code 6.
- R8: Code 7 is raised in three cases: a precharge of an open bank fewer than T_RAS cycles after its activate; an all-bank precharge (A10 high), where the lowest such bank is reported; and a read with A10 high issued at gap g after activate with g+BURST_LEN < T_RAS, or a write with A10 high with g+BURST_LEN-1+T_WR < T_RAS.
- R9: For the BURST_LEN-1 cycles after a read or write with A10 high, a read, write or precharge that touches that bank gives code 8. The auto-precharge itself closes the bank.
- R10: A read or write with A10 high while the full-page flag is set gives code 9.
- R11: After a read with A10 high, an activate of that bank earlier than BURST_LEN+T_RP cycles gives code 6. After a write with A10 high, the limit is BURST_LEN-1+T_WR+T_RP cycles.
- R12: A burst stop gives code 10 unless the full-page flag is set and a full-page read or write is still running. That burst ends at a burst stop, at a precharge of its bank, or at a later non-full-page access.
- R13: A refresh or self-refresh entry while any bank is open gives code 11, reporting the lowest open bank.
- R14: Commands are ignored while CKE was low on the previous edge, including the edge on which CKE returns high. The command on the edge after that must be a no-op or deselect, or code 12 is raised with bank 0. This check takes priority over every other check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| cke | input | 1 | Clock enable |
| a10 | input | 1 | Auto-precharge / all-bank select bit |
| ba | input | BA_W | Bank address |
| cfg_full_page | input | 1 | Device programmed for full-page bursts |
| viol | output | 1 | One-cycle violation flag |
| viol_code | output | 4 | Reason code, 0 when no violation |
| viol_bank | output | BA_W | Bank at fault |

## Verification
The bench uses four banks, BURST_LEN 4, T_RCD 2, T_RAS 8, T_RP 3, T_RC 12, T_RRD 2 and T_WR 2. These limits are short, so every spacing rule can be swept across its boundary, from one cycle too early to one cycle late, with a fresh reset before each trial. T_RAS is set larger than T_RCD+BURST_LEN so that an auto-precharge starting too early can actually occur and be checked. With four banks, the bank field of each report can be swept across every bank.

// File: rtl/sdram_chk_pkg.sv
// Shared types for the SDRAM command timing monitor.
// Assumes: a four-bit reason code is enough for every rule checked.
package sdram_chk_pkg;

    typedef enum logic [3:0] {
        CMD_NONE,
        CMD_DESEL,
        CMD_NOP,
        CMD_ACT,
        CMD_RD,
        CMD_WR,
        CMD_PRE,
        CMD_REF,
        CMD_MRS,
        CMD_BST
    } cmd_e;

    typedef enum logic [3:0] {
        V_NONE       = 4'd0,
        V_NOT_ACTIVE = 4'd1,
        V_TRCD       = 4'd2,
        V_ACT_OPEN   = 4'd3,
        V_TRC        = 4'd4,
        V_TRRD       = 4'd5,
        V_REACT      = 4'd6,
        V_TRAS       = 4'd7,
        V_AP_INTR    = 4'd8,
        V_AP_FULLPG  = 4'd9,
        V_BST        = 4'd10,
        V_REF_OPEN   = 4'd11,
        V_EXIT_NOP   = 4'd12
    } viol_e;

endpackage

// File: rtl/sdram_cmd_decode.sv
// Turns the strobe pins into a command type and tracks clock-enable history.
// Emits CMD_NONE when CKE was low on the previous edge (command not registered)
// and flags the cycle after a low-to-high CKE transition has been seen.
// Assumes: inputs are synchronous to clk.
module sdram_cmd_decode
    import sdram_chk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    input  logic cke,
    output cmd_e cmd_o,
    output logic exit_chk_o
);

    logic cke_q;
    logic wake_q;
    cmd_e raw;

    // Remember CKE of the previous edge and mark the cycle after a wake-up edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cke_q  <= 1'b1;
            wake_q <= 1'b0;
        end else begin
            cke_q  <= cke;
            wake_q <= !cke_q && cke;
        end
    end

    // Decode the strobe pattern into a command type.
    always_comb begin
        if (cs_n) begin
            raw = CMD_DESEL;
        end else begin
            case ({ras_n, cas_n, we_n})
                3'b111:  raw = CMD_NOP;
                3'b011:  raw = CMD_ACT;
                3'b101:  raw = CMD_RD;
                3'b100:  raw = CMD_WR;
                3'b010:  raw = CMD_PRE;
                3'b001:  raw = CMD_REF;
                3'b000:  raw = CMD_MRS;
                default: raw = CMD_BST;
            endcase
        end
    end

    // Gate the command by the registered clock enable.
    always_comb begin
        cmd_o      = cke_q ? raw : CMD_NONE;
        exit_chk_o = wake_q;
    end

endmodule

// File: rtl/sdram_bank_track.sv
// State and timers of one SDRAM bank.
// open flag; cycles since activate (saturating); reactivation hold-off;
// remaining auto-precharge burst cycles. Hold-off counters are loaded with
// N-1 so that an event at gap k is early exactly when k < N.
// Assumes: at most one of the strobes is high in a cycle.
module sdram_bank_track #(
    parameter int CNT_W     = 6,
    parameter int T_RP      = 3,
    parameter int T_WR      = 2,
    parameter int BURST_LEN = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_i,
    input  logic             close_i,
    input  logic             ap_rd_i,
    input  logic             ap_wr_i,
    output logic             active_o,
    output logic [CNT_W-1:0] since_act_o,
    output logic             wait_o,
    output logic             ap_busy_o
);

    localparam logic [CNT_W-1:0] CNT_MAX   = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] HOLD_PRE  = CNT_W'(T_RP - 1);
    localparam logic [CNT_W-1:0] HOLD_RDAP = CNT_W'(BURST_LEN + T_RP - 1);
    localparam logic [CNT_W-1:0] HOLD_WRAP = CNT_W'(BURST_LEN - 1 + T_WR + T_RP - 1);
    localparam logic [CNT_W-1:0] AP_SPAN   = CNT_W'(BURST_LEN - 1);

    logic             open_q;
    logic [CNT_W-1:0] since_q;
    logic [CNT_W-1:0] hold_q;
    logic [CNT_W-1:0] apc_q;

    // Open/closed state of the bank.
    always_ff @(posedge clk) begin
        if (!rst_n)                             open_q <= 1'b0;
        else if (act_i)                         open_q <= 1'b1;
        else if (close_i || ap_rd_i || ap_wr_i) open_q <= 1'b0;
    end

    // Saturating count of cycles since the last activate.
    always_ff @(posedge clk) begin
        if (!rst_n)                 since_q <= CNT_MAX;
        else if (act_i)             since_q <= CNT_W'(1);
        else if (since_q != CNT_MAX) since_q <= since_q + 1'b1;
    end

    // Reactivation hold-off after explicit or automatic precharge.
    always_ff @(posedge clk) begin
        if (!rst_n)                  hold_q <= '0;
        else if (close_i && open_q)  hold_q <= HOLD_PRE;
        else if (ap_rd_i)            hold_q <= HOLD_RDAP;
        else if (ap_wr_i)            hold_q <= HOLD_WRAP;
        else if (hold_q != '0)       hold_q <= hold_q - 1'b1;
    end

    // Remaining cycles of an auto-precharge burst.
    always_ff @(posedge clk) begin
        if (!rst_n)                 apc_q <= '0;
        else if (ap_rd_i || ap_wr_i) apc_q <= AP_SPAN;
        else if (apc_q != '0)       apc_q <= apc_q - 1'b1;
    end

    assign active_o    = open_q;
    assign since_act_o = since_q;
    assign wait_o      = (hold_q != '0);
    assign ap_busy_o   = (apc_q != '0);

endmodule

// File: rtl/sdram_rule_check.sv
// Combinational rule evaluation for the current command.
// Picks one reason code by fixed priority and the bank to report.
// Assumes: per-bank state is the value before this command takes effect.
module sdram_rule_check
    import sdram_chk_pkg::*;
#(
    parameter int NB        = 4,
    parameter int BA_W      = 2,
    parameter int CNT_W     = 6,
    parameter int T_RCD     = 2,
    parameter int T_RC      = 12,
    parameter int T_RAS     = 8,
    parameter int T_RRD     = 2,
    parameter int T_WR      = 2,
    parameter int BURST_LEN = 4
) (
    input  cmd_e                      cmd,
    input  logic [BA_W-1:0]           ba,
    input  logic                      a10,
    input  logic                      full_page,
    input  logic                      exit_chk,
    input  logic [NB-1:0]             active,
    input  logic [NB-1:0][CNT_W-1:0]  since_act,
    input  logic [NB-1:0]             wait_nz,
    input  logic [NB-1:0]             ap_busy,
    input  logic [CNT_W-1:0]          since_any_act,
    input  logic                      fp_run,
    output viol_e                     code,
    output logic [BA_W-1:0]           bank
);

    logic            any_ap;
    logic            any_early;
    logic            any_open;
    logic [BA_W-1:0] ap_idx;
    logic [BA_W-1:0] early_idx;
    logic [BA_W-1:0] open_idx;
    int              gap;

    // Lowest bank in each cross-bank condition (used by all-bank commands).
    always_comb begin
        any_ap    = 1'b0;
        any_early = 1'b0;
        any_open  = 1'b0;
        ap_idx    = '0;
        early_idx = '0;
        open_idx  = '0;
        for (int i = NB - 1; i >= 0; i--) begin
            if (ap_busy[i]) begin
                any_ap = 1'b1;
                ap_idx = BA_W'(i);
            end
            if (active[i] && int'(since_act[i]) < T_RAS) begin
                any_early = 1'b1;
                early_idx = BA_W'(i);
            end
            if (active[i] || ap_busy[i]) begin
                any_open = 1'b1;
                open_idx = BA_W'(i);
            end
        end
    end

    // Evaluate the rules for the current command in priority order.
    always_comb begin
        code = V_NONE;
        bank = ba;
        gap  = int'(since_act[ba]);
        if (exit_chk && !(cmd inside {CMD_NONE, CMD_NOP, CMD_DESEL})) begin
            code = V_EXIT_NOP;
            bank = '0;
        end else begin
            case (cmd)
                CMD_ACT: begin
                    if (active[ba] || ap_busy[ba])           code = V_ACT_OPEN;
                    else if (wait_nz[ba])                    code = V_REACT;
                    else if (gap < T_RC)                     code = V_TRC;
                    else if (int'(since_any_act) < T_RRD)    code = V_TRRD;
                end
                CMD_RD, CMD_WR: begin
                    if (ap_busy[ba])                         code = V_AP_INTR;
                    else if (!active[ba])                    code = V_NOT_ACTIVE;
                    else if (gap < T_RCD)                    code = V_TRCD;
                    else if (a10 && full_page)               code = V_AP_FULLPG;
                    else if (a10 && cmd == CMD_RD && gap + BURST_LEN < T_RAS)
                                                             code = V_TRAS;
                    else if (a10 && cmd == CMD_WR && gap + BURST_LEN - 1 + T_WR < T_RAS)
                                                             code = V_TRAS;
                end
                CMD_PRE: begin
                    if (a10) begin
                        if (any_ap) begin
                            code = V_AP_INTR;
                            bank = ap_idx;
                        end else if (any_early) begin
                            code = V_TRAS;
                            bank = early_idx;
                        end
                    end else begin
                        if (ap_busy[ba])                     code = V_AP_INTR;
                        else if (active[ba] && gap < T_RAS)  code = V_TRAS;
                    end
                end
                CMD_REF: begin
                    if (any_open) begin
                        code = V_REF_OPEN;
                        bank = open_idx;
                    end
                end
                CMD_BST: begin
                    if (!(full_page && fp_run))              code = V_BST;
                end
                default: code = V_NONE;
            endcase
        end
    end

endmodule

// File: rtl/sdram_cmd_checker.sv
// Top of the SDRAM command timing monitor.
// Decodes bus commands, keeps per-bank state, and registers a one-cycle
// violation report with a reason code and bank.
// Assumes: passive observation only; limits are given in clock cycles.
module sdram_cmd_checker
    import sdram_chk_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int T_RCD     = 2,
    parameter int T_RC      = 12,
    parameter int T_RAS     = 8,
    parameter int T_RP      = 3,
    parameter int T_RRD     = 2,
    parameter int T_WR      = 2,
    parameter int BURST_LEN = 4,
    localparam int BA_W     = $clog2(NUM_BANKS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cs_n,
    input  logic            ras_n,
    input  logic            cas_n,
    input  logic            we_n,
    input  logic            cke,
    input  logic            a10,
    input  logic [BA_W-1:0] ba,
    input  logic            cfg_full_page,
    output logic            viol,
    output logic [3:0]      viol_code,
    output logic [BA_W-1:0] viol_bank
);

    localparam int CNT_W = $clog2(T_RC + T_RAS + T_RP + T_WR + T_RRD + T_RCD + BURST_LEN + 1) + 1;
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    cmd_e                         cmd_dec;
    logic                         exit_chk;
    logic [NUM_BANKS-1:0]         bank_active;
    logic [NUM_BANKS-1:0][CNT_W-1:0] bank_since;
    logic [NUM_BANKS-1:0]         bank_wait;
    logic [NUM_BANKS-1:0]         bank_ap;
    logic [CNT_W-1:0]             since_any_act;
    logic                         fp_run;
    logic [BA_W-1:0]              fp_bank;
    viol_e                        code_c;
    logic [BA_W-1:0]              bank_c;

    sdram_cmd_decode u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .ras_n      (ras_n),
        .cas_n      (cas_n),
        .we_n       (we_n),
        .cke        (cke),
        .cmd_o      (cmd_dec),
        .exit_chk_o (exit_chk)
    );

    for (genvar gi = 0; gi < NUM_BANKS; gi++) begin : g_bank
        logic hit;
        assign hit = (ba == BA_W'(gi));
        sdram_bank_track #(
            .CNT_W     (CNT_W),
            .T_RP      (T_RP),
            .T_WR      (T_WR),
            .BURST_LEN (BURST_LEN)
        ) u_trk (
            .clk         (clk),
            .rst_n       (rst_n),
            .act_i       (cmd_dec == CMD_ACT && hit),
            .close_i     (cmd_dec == CMD_PRE && (a10 || hit)),
            .ap_rd_i     (cmd_dec == CMD_RD && a10 && hit),
            .ap_wr_i     (cmd_dec == CMD_WR && a10 && hit),
            .active_o    (bank_active[gi]),
            .since_act_o (bank_since[gi]),
            .wait_o      (bank_wait[gi]),
            .ap_busy_o   (bank_ap[gi])
        );
    end

    // Cycles since the last activate to any bank, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)                        since_any_act <= CNT_MAX;
        else if (cmd_dec == CMD_ACT)       since_any_act <= CNT_W'(1);
        else if (since_any_act != CNT_MAX) since_any_act <= since_any_act + 1'b1;
    end

    // Track whether a full-page burst is running and on which bank.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fp_run  <= 1'b0;
            fp_bank <= '0;
        end else begin
            case (cmd_dec)
                CMD_RD, CMD_WR: begin
                    fp_run  <= cfg_full_page && !a10;
                    fp_bank <= ba;
                end
                CMD_BST: fp_run <= 1'b0;
                CMD_PRE: if (a10 || ba == fp_bank) fp_run <= 1'b0;
                default: fp_run <= fp_run;
            endcase
        end
    end

    sdram_rule_check #(
        .NB        (NUM_BANKS),
        .BA_W      (BA_W),
        .CNT_W     (CNT_W),
        .T_RCD     (T_RCD),
        .T_RC      (T_RC),
        .T_RAS     (T_RAS),
        .T_RRD     (T_RRD),
        .T_WR      (T_WR),
        .BURST_LEN (BURST_LEN)
    ) u_rules (
        .cmd           (cmd_dec),
        .ba            (ba),
        .a10           (a10),
        .full_page     (cfg_full_page),
        .exit_chk      (exit_chk),
        .active        (bank_active),
        .since_act     (bank_since),
        .wait_nz       (bank_wait),
        .ap_busy       (bank_ap),
        .since_any_act (since_any_act),
        .fp_run        (fp_run),
        .code          (code_c),
        .bank          (bank_c)
    );

    // Register the report so it pulses for one cycle after the command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            viol      <= 1'b0;
            viol_code <= 4'd0;
            viol_bank <= '0;
        end else begin
            viol      <= (code_c != V_NONE);
            viol_code <= code_c;
            viol_bank <= bank_c;
        end
    end

endmodule

// File: rtl/sdram_cmd_checker_sva.sv
// Property checker for the SDRAM command timing monitor, bound to the top.
// Relates the decoded command and bank state to the registered report.
module sdram_cmd_checker_sva
    import sdram_chk_pkg::*;
#(
    parameter int NB    = 4,
    parameter int BA_W  = 2,
    parameter int CNT_W = 6,
    parameter int T_RCD = 2
) (
    input logic                     clk,
    input logic                     rst_n,
    input cmd_e                     cmd,
    input logic                     exit_chk,
    input logic [BA_W-1:0]          ba,
    input logic [NB-1:0]            active,
    input logic [NB-1:0]            ap_busy,
    input logic [NB-1:0][CNT_W-1:0] since_act,
    input logic                     cfg_full_page,
    input logic                     viol,
    input logic [3:0]               viol_code
);

    a_r1_quiet_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd inside {CMD_NONE, CMD_NOP, CMD_DESEL} && !exit_chk) |=> !viol);

    a_r4_act_open: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_ACT && active[ba] && !exit_chk) |=> (viol && viol_code == 4'd3));

    a_r2_trcd: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd == CMD_RD || cmd == CMD_WR) && active[ba] && !ap_busy[ba]
         && since_act[ba] < CNT_W'(T_RCD) && !exit_chk) |=> (viol_code == 4'd2));

    a_r12_bst_fixed_len: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_BST && !cfg_full_page && !exit_chk) |=> (viol_code == 4'd10));

    a_r13_ref_open: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_REF && (|active) && !exit_chk) |=> (viol_code == 4'd11));

endmodule

bind sdram_cmd_checker sdram_cmd_checker_sva #(
    .NB    (NUM_BANKS),
    .BA_W  (BA_W),
    .CNT_W (CNT_W),
    .T_RCD (T_RCD)
) u_sva (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd           (cmd_dec),
    .exit_chk      (exit_chk),
    .ba            (ba),
    .active        (bank_active),
    .ap_busy       (bank_ap),
    .since_act     (bank_since),
    .cfg_full_page (cfg_full_page),
    .viol          (viol),
    .viol_code     (viol_code)
);

// File: tb/sdram_cmd_checker_bench.sv
module sdram_cmd_checker_bench;

    localparam int NB = 4, RCD = 2, RC = 12, RAS = 8, RP = 3, RRD = 2, WR = 2, BL = 4;
    localparam logic [3:0] K_NOP = 4'b0111, K_DES = 4'b1111, K_ACT = 4'b0011,
                           K_RD  = 4'b0101, K_WR  = 4'b0100, K_PRE = 4'b0010,
                           K_REF = 4'b0001, K_BST = 4'b0110, K_DACT = 4'b1011;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic cke = 1'b1, a10 = 1'b0, cfg_full_page = 1'b0;
    logic [1:0] ba = '0;
    logic viol;
    logic [3:0] viol_code;
    logic [1:0] viol_bank;

    int vectors = 0, miscompares = 0;
    logic got_v;
    int got_c, got_b;
    bit done = 0;

    always #10 clk = ~clk;

    sdram_cmd_checker #(
        .NUM_BANKS(NB), .T_RCD(RCD), .T_RC(RC), .T_RAS(RAS),
        .T_RP(RP), .T_RRD(RRD), .T_WR(WR), .BURST_LEN(BL)
    ) u_sdram_cmd_checker (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .cke(cke), .a10(a10), .ba(ba), .cfg_full_page(cfg_full_page),
        .viol(viol), .viol_code(viol_code), .viol_bank(viol_bank)
    );

    task automatic sample();
        got_v = viol;
        got_c = int'(viol_code);
        got_b = int'(viol_bank);
    endtask

    // Drive one command at a falling edge; sample the report one period later.
    task automatic step(input logic [3:0] k, input int b, input logic ap);
        {cs_n, ras_n, cas_n, we_n} = k;
        ba  = 2'(b);
        a10 = ap;
        @(negedge clk);
        sample();
    endtask

    task automatic nops(input int n);
        for (int i = 0; i < n; i++) step(K_NOP, 0, 1'b0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        cke = 1'b1;
        cfg_full_page = 1'b0;
        {cs_n, ras_n, cas_n, we_n} = K_NOP;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        sample();
    endtask

    task automatic check(input string tag, input int ec, input int eb);
        vectors++;
        if (got_v !== (ec != 0) || got_c != ec || (ec != 0 && got_b != eb)) begin
            miscompares++;
            $display("FAIL %s: flag %0b code %0d bank %0d, expected flag %0b code %0d bank %0d",
                     tag, got_v, got_c, got_b, ec != 0, ec, eb);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL R1 watchdog expired: run incomplete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        check("R1 reset state", 0, 0);
        step(K_NOP, 0, 0);  check("R1 nop quiet", 0, 0);
        step(K_DES, 3, 1);  check("R1 deselect quiet", 0, 0);

        // R2: read/write spacing after activate, every bank
        for (int b = 0; b < NB; b++)
            for (int g = 1; g <= RCD + 1; g++)
                for (int w = 0; w < 2; w++) begin
                    do_reset();
                    step(K_ACT, b, 0); check("R2 activate legal", 0, b);
                    nops(g - 1);
                    step(w ? K_WR : K_RD, b, 0);
                    check("R2 tRCD", (g < RCD) ? 2 : 0, b);
                    step(K_NOP, 0, 0); check("R1 single-cycle pulse", 0, 0);
                end

        // R3: access to closed bank; deselect carrying activate pattern
        for (int b = 0; b < NB; b++) begin
            do_reset();
            step(K_DACT, b, 0); check("R3 deselect no effect", 0, 0);
            nops(3);
            step(K_RD, b, 0); check("R3 read closed bank", 1, b);
            step(K_WR, b, 0); check("R3 write closed bank", 1, b);
        end

        // R4: activate to an open bank
        for (int b = 0; b < NB; b++) begin
            do_reset();
            step(K_ACT, b, 0); nops(RC);
            step(K_ACT, b, 0); check("R4 activate open bank", 3, b);
        end

        // R5: same-bank activate spacing
        for (int g = RAS + RP; g <= RC + 1; g++) begin
            do_reset();
            step(K_ACT, 0, 0); nops(RAS - 1);
            step(K_PRE, 0, 0); check("R8 precharge at tRAS legal", 0, 0);
            nops(g - RAS - 1);
            step(K_ACT, 0, 0); check("R5 tRC", (g < RC) ? 4 : 0, 0);
        end

        // R6: cross-bank activate spacing
        for (int b = 0; b < NB; b++)
            for (int g = 1; g <= RRD + 1; g++) begin
                do_reset();
                step(K_ACT, b, 0); nops(g - 1);
                step(K_ACT, (b + 1) % NB, 0);
                check("R6 tRRD", (g < RRD) ? 5 : 0, (b + 1) % NB);
            end

        // R7: precharge to activate
        for (int g = 1; g <= RP + 1; g++) begin
            do_reset();
            step(K_ACT, 2, 0); nops(RC - 1);
            step(K_PRE, 2, 0); nops(g - 1);
            step(K_ACT, 2, 0); check("R7 tRP", (g < RP) ? 6 : 0, 2);
        end

        // R8: activate to precharge, single and all-bank
        for (int g = 1; g <= RAS + 1; g++) begin
            do_reset();
            step(K_ACT, 1, 0); nops(g - 1);
            step(K_PRE, 1, 0); check("R8 tRAS single", (g < RAS) ? 7 : 0, 1);
            do_reset();
            step(K_ACT, 3, 0); nops(g - 1);
            step(K_PRE, 0, 1); check("R8 tRAS all-bank", (g < RAS) ? 7 : 0, 3);
        end
        // R8: auto-precharge start versus tRAS
        for (int g = RCD; g <= RAS; g++)
            for (int w = 0; w < 2; w++) begin
                do_reset();
                step(K_ACT, 0, 0); nops(g - 1);
                step(w ? K_WR : K_RD, 0, 1);
                check("R8 tRAS auto-precharge",
                      ((w ? g + BL - 1 + WR : g + BL) < RAS) ? 7 : 0, 0);
            end

        // R9: auto-precharge burst cannot be interrupted
        for (int k = 1; k <= BL; k++) begin
            do_reset();
            step(K_ACT, 1, 0); nops(RAS - 1);
            step(K_RD, 1, 1); check("R9 read auto-precharge legal", 0, 1);
            nops(k - 1);
            step(K_RD, 1, 0); check("R9 interrupt by read", (k < BL) ? 8 : 1, 1);
        end
        do_reset();
        step(K_ACT, 2, 0); nops(RAS - 1);
        step(K_WR, 2, 1); step(K_PRE, 2, 0); check("R9 interrupt by precharge", 8, 2);

        // R10: auto-precharge in full-page mode
        do_reset();
        cfg_full_page = 1'b1;
        step(K_ACT, 0, 0); nops(RAS - 1);
        step(K_RD, 0, 1); check("R10 auto-precharge full page", 9, 0);

        // R11: reactivation after auto-precharge
        for (int w = 0; w < 2; w++)
            for (int g = BL; g <= 10; g++) begin
                do_reset();
                step(K_ACT, 3, 0); nops(RAS - 1);
                step(w ? K_WR : K_RD, 3, 1); nops(g - 1);
                step(K_ACT, 3, 0);
                check("R11 reactivate after auto-precharge",
                      (g < (w ? BL - 1 + WR + RP : BL + RP)) ? 6 : 0, 3);
            end

        // R12: burst stop
        do_reset();
        step(K_ACT, 0, 0); nops(RCD);
        step(K_RD, 0, 0); step(K_BST, 0, 0); check("R12 stop fixed length", 10, 0);
        do_reset();
        cfg_full_page = 1'b1;
        step(K_BST, 1, 0); check("R12 stop with no burst", 10, 1);
        step(K_ACT, 1, 0); nops(RCD);
        step(K_WR, 1, 0); step(K_NOP, 0, 0);
        step(K_BST, 1, 0); check("R12 stop full-page burst", 0, 1);
        step(K_BST, 1, 0); check("R12 second stop", 10, 1);

        // R13: refresh with open banks
        do_reset();
        step(K_REF, 0, 0); check("R13 refresh all idle", 0, 0);
        for (int b = 0; b < NB; b++) begin
            do_reset();
            step(K_ACT, b, 0); nops(2);
            step(K_REF, 0, 0); check("R13 refresh open bank", 11, b);
            cke = 1'b0;
            step(K_REF, 0, 0); check("R13 self-refresh entry open bank", 11, b);
            cke = 1'b1;
        end

        // R14: clock-enable exit
        for (int v = 0; v < 2; v++) begin
            do_reset();
            cke = 1'b0;
            step(K_NOP, 0, 0); check("R14 entry nop", 0, 0);
            step(K_RD, 1, 0); check("R14 ignored while low", 0, 0);
            cke = 1'b1;
            step(K_RD, 1, 0); check("R14 ignored on wake edge", 0, 0);
            step(v ? K_NOP : K_RD, 1, 0); check("R14 exit slot", v ? 0 : 12, 0);
            step(K_RD, 1, 0); check("R14 normal after exit", 1, 1);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule